// File: doc/BRIEF.md
# Segmented Posted Write Buffer

This block holds posted write data travelling in one direction through a bus bridge. Its storage is a pool of fixed-size segments. A transaction takes a segment from the pool whenever it needs room for more data, so a short write ties up one segment and a long one takes as many as it needs. Each segment goes back to the pool the moment its last beat has been read out, and any transaction may take it again.

The initiating side delivers 32-bit beats. A start marker on the first beat carries the write address, and a last marker closes the transaction. A transaction descriptor queue records, in arrival order, the address of each write and the ring of segment indices it has been given. The target side does not wait for a transaction to complete. As soon as a segment is closed, either because it holds 32 beats or because the last marker arrived, its beats are offered at the output. Each beat is tagged with the transaction address and with flags for the first beat, the segment end and the transaction end.

The input is back-pressured only when a beat needs a fresh segment and none is free, or when a new transaction starts while the descriptor queue is full.

Top module: `pwb_posted_buf`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1 (all eight segments free, descriptor queue empty).
- R2: Every accepted beat leaves the output exactly once. Beats leave in the order they were accepted and transactions leave in arrival order. Each output beat carries the start address of its transaction on `out_addr`, and `out_first` is 1 only on a transaction's first beat.
- R3: A segment holds 32 beats. Counting beats of a transaction from 0, `out_seg_end` is 1 on beat indices 31, 63, 95, ... and on the transaction's final beat. `out_last` is 1 only on the final beat.
- R4: Forwarding starts per segment. When a transaction's 32nd beat is accepted, `out_valid` is 1 in the next cycle even though the last beat has not arrived. Before that beat it stays 0.
- R5: When a transaction's last beat closes a partly filled segment, that segment is offered on the next cycle. A one-beat transaction shows `out_first`, `out_seg_end` and `out_last` all at 1.
- R6: Capacity is eight segments. With the output stalled, beats that continue a segment already held are accepted even when no segment is free. A beat that needs a new segment sees `in_ready` at 0 while none is free.
- R7: At most eight transactions can be outstanding. A start-marked beat sees `in_ready` at 0 while eight descriptors are held.
- R8: A segment is reusable as soon as it is drained. A writer stalled for lack of segments is accepted in the cycle after the handshake of the 32nd beat of the oldest full segment. A transaction longer than 256 beats is carried by reusing segments.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be accepted |
| in_first | input | 1 | Beat opens a new transaction; `in_addr` is captured |
| in_last | input | 1 | Beat closes the transaction |
| in_addr | input | 32 | Transaction start address, sampled with `in_first` |
| in_data | input | 32 | Write data beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Target side takes the beat |
| out_first | output | 1 | First beat of a transaction |
| out_seg_end | output | 1 | Final beat of a segment |
| out_last | output | 1 | Final beat of a transaction |
| out_addr | output | 32 | Start address of the transaction being drained |
| out_data | output | 32 | Data beat |

## Verification
The assertions take for granted that the initiator puts the start marker on the first beat of every transaction and on no other beat, and that it does not open a new transaction until the previous one has ended with a last marker. They also assume a held output beat is not withdrawn by the target side. The bench only generates whole transactions from a length counter, so markers always come in that pairing. It keeps `in_valid` and the beat fields steady until the handshake, and it changes `out_ready` only between cycles.

// File: rtl/pwb_pkg.sv
// Package: default geometry shared by the segmented posted write buffer.
// Assumes segment count, beats per segment and queue depth are powers of two.
package pwb_pkg;
    localparam int PWB_DATA_W    = 32;
    localparam int PWB_ADDR_W    = 32;
    localparam int PWB_SEGS      = 8;
    localparam int PWB_SEG_BEATS = 32;
    localparam int PWB_TXN_DEPTH = 8;
endpackage

// File: rtl/pwb_free_pool.sv
// Free pool: bitmap of unused segments and the lowest-index free segment.
// Assumes the caller only takes when any_free is set and never puts back a free segment.
module pwb_free_pool #(
    parameter int NSEG = 8,
    localparam int IW  = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            put,
    input  logic [IW-1:0]   put_idx,
    output logic            any_free,
    output logic [IW-1:0]   take_idx,
    output logic [NSEG-1:0] free_map
);
    // Pick the lowest free segment.
    always_comb begin
        take_idx = '0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (free_map[i]) take_idx = IW'(i);
        end
    end

    assign any_free = |free_map;

    // Clear the taken bit and set the returned bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_map <= '1;
        end else begin
            if (take) free_map[take_idx] <= 1'b0;
            if (put)  free_map[put_idx]  <= 1'b1;
        end
    end
endmodule

// File: rtl/pwb_txn_queue.sv
// Transaction queue: per-transaction start address and a ring of segment indices.
// The newest entry grows as the writer adds segments; the oldest is read by the drain side.
// Assumes push and grow are exclusive and that at most NSEG segments are held at once.
module pwb_txn_queue #(
    parameter int DEPTH  = 8,
    parameter int NSEG   = 8,
    parameter int ADDR_W = 32,
    localparam int IW    = $clog2(NSEG),
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [IW-1:0]     push_seg,
    input  logic              grow,
    input  logic [IW-1:0]     grow_seg,
    input  logic              pop,
    input  logic [IW:0]       rd_pos,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] head_addr,
    output logic [IW:0]       head_nalloc,
    output logic [IW-1:0]     head_seg
);
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [IW-1:0]     segs_q [DEPTH][NSEG];
    logic [IW:0]       nalloc_q [DEPTH];
    logic [PW-1:0]     wptr, rptr, cur;
    logic [PW:0]       count;

    assign cur         = wptr - 1'b1;
    assign full        = (count == (PW+1)'(DEPTH));
    assign empty       = (count == '0);
    assign head_addr   = addr_q[rptr];
    assign head_nalloc = nalloc_q[rptr];
    assign head_seg    = segs_q[rptr][rd_pos[IW-1:0]];

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            count <= count + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    // Record a new transaction or append a segment to the newest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) nalloc_q[e] <= '0;
        end else if (push) begin
            addr_q[wptr]      <= push_addr;
            segs_q[wptr][0]   <= push_seg;
            nalloc_q[wptr]    <= (IW+1)'(1);
        end else if (grow) begin
            segs_q[cur][nalloc_q[cur][IW-1:0]] <= grow_seg;
            nalloc_q[cur] <= nalloc_q[cur] + 1'b1;
        end
    end
endmodule

// File: rtl/pwb_seg_store.sv
// Segment store: data memory plus per-segment closed flag, final-beat index and end-of-transaction flag.
// Assumes a segment is never closed and released in the same cycle.
module pwb_seg_store #(
    parameter int NSEG      = 8,
    parameter int SEG_BEATS = 32,
    parameter int DATA_W    = 32,
    localparam int IW       = $clog2(NSEG),
    localparam int BW       = $clog2(SEG_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_seg,
    input  logic [BW-1:0]     wr_beat,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              close,
    input  logic              close_tail,
    input  logic              rel,
    input  logic [IW-1:0]     rel_seg,
    input  logic [IW-1:0]     rd_seg,
    input  logic [BW-1:0]     rd_beat,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic [BW-1:0]     rd_lastidx,
    output logic              rd_tail
);
    logic [DATA_W-1:0] mem [NSEG*SEG_BEATS];
    logic [NSEG-1:0]   done_q;
    logic [NSEG-1:0]   tail_q;
    logic [BW-1:0]     last_q [NSEG];

    // Store each accepted beat at its segment slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_seg, wr_beat}] <= wr_data;
    end

    // Per-segment closed state.
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q[s] <= 1'b0;
                tail_q[s] <= 1'b0;
                last_q[s] <= '0;
            end else if (close && wr_seg == IW'(s)) begin
                done_q[s] <= 1'b1;
                tail_q[s] <= close_tail;
                last_q[s] <= wr_beat;
            end else if (rel && rel_seg == IW'(s)) begin
                done_q[s] <= 1'b0;
            end
        end
    end

    assign rd_data    = mem[{rd_seg, rd_beat}];
    assign rd_done    = done_q[rd_seg];
    assign rd_lastidx = last_q[rd_seg];
    assign rd_tail    = tail_q[rd_seg];
endmodule

// File: rtl/pwb_posted_buf.sv
// Segmented posted write buffer (top). The write side takes segments from the free pool as
// beats arrive. The drain side releases each segment after its final beat leaves.
// Assumes in_first marks exactly the first beat of each transaction, and that a new
// transaction starts only after the previous one has seen in_last.
module pwb_posted_buf
    import pwb_pkg::*;
#(
    parameter int DATA_W    = PWB_DATA_W,
    parameter int ADDR_W    = PWB_ADDR_W,
    parameter int NSEG      = PWB_SEGS,
    parameter int SEG_BEATS = PWB_SEG_BEATS,
    parameter int TXN_DEPTH = PWB_TXN_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_first,
    output logic              out_seg_end,
    output logic              out_last,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    localparam int IW = $clog2(NSEG);
    localparam int BW = $clog2(SEG_BEATS);

    logic              any_free, q_full, q_empty;
    logic [IW-1:0]     take_idx, wr_seg, wseg, head_seg;
    logic [NSEG-1:0]   free_map;
    logic [BW-1:0]     wr_beat, wbeat, rd_beat, rd_lastidx;
    logic              wr_open, need_seg, acc, seg_close, take;
    logic [ADDR_W-1:0] head_addr;
    logic [IW:0]       head_nalloc, rd_pos;
    logic              rd_done, rd_tail, seg_last, fire, rel;

    // Write-side decode: a beat needs a segment when it opens a transaction or the previous one filled.
    assign need_seg  = in_first || !wr_open;
    assign in_ready  = !need_seg || (any_free && !(in_first && q_full));
    assign acc       = in_valid && in_ready;
    assign take      = acc && need_seg;
    assign wseg      = need_seg ? take_idx : wr_seg;
    assign wbeat     = need_seg ? '0 : wr_beat;
    assign seg_close = acc && (in_last || wbeat == BW'(SEG_BEATS - 1));

    // Track the segment being filled and the beat position inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open <= 1'b0;
            wr_seg  <= '0;
            wr_beat <= '0;
        end else if (acc) begin
            wr_seg  <= wseg;
            wr_open <= !seg_close;
            wr_beat <= seg_close ? '0 : wbeat + 1'b1;
        end
    end

    // Drain-side decode: the next segment of the oldest transaction must be allocated and closed.
    assign out_valid   = !q_empty && (head_nalloc != rd_pos) && rd_done;
    assign fire        = out_valid && out_ready;
    assign seg_last    = (rd_beat == rd_lastidx);
    assign rel         = fire && seg_last;
    assign out_first   = (rd_pos == '0) && (rd_beat == '0);
    assign out_seg_end = seg_last;
    assign out_last    = seg_last && rd_tail;
    assign out_addr    = head_addr;

    // Advance through beats, then segments, then transactions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pos  <= '0;
            rd_beat <= '0;
        end else if (fire) begin
            if (seg_last) begin
                rd_beat <= '0;
                rd_pos  <= rd_tail ? '0 : rd_pos + 1'b1;
            end else begin
                rd_beat <= rd_beat + 1'b1;
            end
        end
    end

    pwb_free_pool #(.NSEG(NSEG)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .put      (rel),
        .put_idx  (head_seg),
        .any_free (any_free),
        .take_idx (take_idx),
        .free_map (free_map)
    );

    pwb_txn_queue #(.DEPTH(TXN_DEPTH), .NSEG(NSEG), .ADDR_W(ADDR_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (acc && in_first),
        .push_addr   (in_addr),
        .push_seg    (take_idx),
        .grow        (take && !in_first),
        .grow_seg    (take_idx),
        .pop         (rel && rd_tail),
        .rd_pos      (rd_pos),
        .full        (q_full),
        .empty       (q_empty),
        .head_addr   (head_addr),
        .head_nalloc (head_nalloc),
        .head_seg    (head_seg)
    );

    pwb_seg_store #(.NSEG(NSEG), .SEG_BEATS(SEG_BEATS), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (acc),
        .wr_seg     (wseg),
        .wr_beat    (wbeat),
        .wr_data    (in_data),
        .close      (seg_close),
        .close_tail (in_last),
        .rel        (rel),
        .rel_seg    (head_seg),
        .rd_seg     (head_seg),
        .rd_beat    (rd_beat),
        .rd_data    (out_data),
        .rd_done    (rd_done),
        .rd_lastidx (rd_lastidx),
        .rd_tail    (rd_tail)
    );
endmodule

// File: rtl/pwb_posted_buf_chk.sv
// Checker for the segmented posted write buffer, attached to the top by bind.
// Assumes well-formed start/last pairing on the input, as stated in the brief.
module pwb_posted_buf_chk #(
    parameter int NSEG   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int IW    = $clog2(NSEG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_first,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              q_full,
    input logic              take,
    input logic [IW-1:0]     take_idx,
    input logic              rel,
    input logic [IW-1:0]     rel_idx,
    input logic [NSEG-1:0]   free_map
);
    // R9: a stalled output beat stays put.
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr));

    // R7: no transaction opens while the descriptor queue is full.
    p_txn_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_first && q_full |-> !in_ready);

    // R6: a segment is only handed out while the pool marks it free.
    p_take_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> free_map[take_idx]);

    // R8: only a held segment is returned, and it is free one cycle later.
    p_release_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> !free_map[rel_idx]);

    p_release_reuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> free_map[$past(rel_idx)]);
endmodule

bind pwb_posted_buf pwb_posted_buf_chk #(.NSEG(NSEG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_first  (in_first),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_addr  (out_addr),
    .q_full    (q_full),
    .take      (take),
    .take_idx  (take_idx),
    .rel       (rel),
    .rel_idx   (head_seg),
    .free_map  (free_map)
);

// File: tb/pwb_posted_buf_tb.sv
// Bench for the segmented posted write buffer: directed corners, then seeded random traffic,
// checked against a reference queue of expected beats.
module pwb_posted_buf_tb;
    localparam int SEGB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [31:0] in_addr = '0, in_data = '0;
    logic        in_ready, out_valid, out_first, out_seg_end, out_last;
    logic [31:0] out_addr, out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit last_acc, last_fire;
    int cur_idx = 0;

    logic [31:0] m_addr[$], m_data[$];
    bit          m_first[$], m_seg[$], m_last[$];

    always #2 clk = ~clk;

    pwb_posted_buf u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first),
        .out_seg_end(out_seg_end), .out_last(out_last), .out_addr(out_addr), .out_data(out_data)
    );

    // Expected segment-end flag for beat idx of a transaction.
    function automatic bit exp_seg_end(int idx, bit last);
        return ((idx % SEGB) == SEGB - 1) || last;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: observe handshakes just before the edge, return after the next falling edge.
    task automatic cycle();
        #1;
        last_acc  = in_valid && in_ready;
        last_fire = out_valid && out_ready;
        if (last_fire) begin
            if (m_data.size() == 0) begin
                check(0, "R2", "beat with nothing expected", 64'(out_data), 64'h0);
            end else begin
                check(out_data == m_data[0] && out_addr == m_addr[0] && out_first == m_first[0],
                      "R2", "data/addr/first", {out_addr, out_data}, {m_addr[0], m_data[0]});
                check(out_seg_end == m_seg[0] && out_last == m_last[0], "R3", "seg_end/last",
                      64'({out_seg_end, out_last}), 64'({m_seg[0], m_last[0]}));
                void'(m_addr.pop_front()); void'(m_data.pop_front());
                void'(m_first.pop_front()); void'(m_seg.pop_front()); void'(m_last.pop_front());
            end
        end
        if (last_acc) begin
            int idx;
            idx = in_first ? 0 : cur_idx;
            if (in_first) m_addr.push_back(in_addr);
            else m_addr.push_back(m_addr.size() > 0 ? m_addr[$] : cur_addr);
            m_data.push_back(in_data);
            m_first.push_back(idx == 0);
            m_seg.push_back(exp_seg_end(idx, in_last));
            m_last.push_back(in_last);
            cur_idx = idx + 1;
            if (in_first) cur_addr = in_addr;
        end
        @(negedge clk);
    endtask

    logic [31:0] cur_addr = '0;

    task automatic send_beat(bit first, bit last, logic [31:0] addr, logic [31:0] data);
        in_valid = 1'b1; in_first = first; in_last = last; in_addr = addr; in_data = data;
        do cycle(); while (!last_acc);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_txn(int len, logic [31:0] addr);
        for (int i = 0; i < len; i++) send_beat(i == 0, i == len - 1, addr, $urandom);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        out_ready = 1'b1;
        while (m_data.size() > 0) cycle();
        cycle();
        check(!out_valid, "R2", "no extra beats after drain", 64'(out_valid), 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int gen_left;
        int nf;
        logic [31:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);

        // R4: forwarding starts once the first segment is full
        out_ready = 1'b0;
        for (int i = 0; i < 31; i++) send_beat(i == 0, 1'b0, 32'hA000_0100, $urandom);
        check(out_valid == 1'b0, "R4", "idle before 32nd beat", 64'(out_valid), 64'h0);
        send_beat(1'b0, 1'b0, 32'hA000_0100, $urandom);
        check(out_valid == 1'b1, "R4", "valid after 32nd beat", 64'(out_valid), 64'h1);
        check(out_first == 1'b1, "R4", "first flag at cut-through", 64'(out_first), 64'h1);
        for (int i = 0; i < 8; i++) send_beat(1'b0, i == 7, 32'hA000_0100, $urandom);
        drain();

        // R5: one-beat transaction
        out_ready = 1'b0;
        send_beat(1'b1, 1'b1, 32'hB000_0040, 32'h1234_5678);
        check(out_valid && out_first && out_seg_end && out_last, "R5", "one-beat flags",
              64'({out_valid, out_first, out_seg_end, out_last}), 64'hF);
        drain();

        // R9: held output under stall
        out_ready = 1'b0;
        send_txn(3, 32'hC000_0000);
        held = out_data;
        repeat (3) cycle();
        check(out_valid && out_data == held, "R9", "stalled beat holds", 64'(out_data), 64'(held));
        drain();

        // R6 / R8: fill all eight segments, then resume on reuse
        out_ready = 1'b0;
        for (int i = 0; i < 255; i++) send_beat(i == 0, 1'b0, 32'hD000_0000, $urandom);
        check(in_ready == 1'b1, "R6", "continuation beat with pool empty", 64'(in_ready), 64'h1);
        send_beat(1'b0, 1'b0, 32'hD000_0000, $urandom);
        check(in_ready == 1'b0, "R6", "new segment refused when none free", 64'(in_ready), 64'h0);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b0; in_data = $urandom;
        out_ready = 1'b1;
        nf = 0;
        forever begin
            cycle();
            if (last_acc) break;
            if (last_fire) nf++;
        end
        check(nf == 32, "R8", "fires before stalled writer resumes", 64'(nf), 64'd32);
        in_valid = 1'b0;
        send_beat(1'b0, 1'b1, 32'hD000_0000, $urandom);
        drain();

        // R7: descriptor queue limit
        out_ready = 1'b0;
        for (int t = 0; t < 8; t++) send_txn(1, 32'hE000_0000 + 32'(t));
        in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1; in_addr = 32'hE000_00FF;
        #1;
        check(in_ready == 1'b0, "R7", "ninth transaction refused", 64'(in_ready), 64'h0);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        drain();

        // Random traffic (R2, R3, R8)
        gen_left = 0;
        for (int c = 0; c < 6000; c++) begin
            if (!in_valid && ($urandom % 4 != 0)) begin
                if (gen_left == 0) begin
                    gen_left = ($urandom % 5 == 0) ? 1 + ($urandom % 300) : 1 + ($urandom % 8);
                    in_first = 1'b1;
                    in_addr  = $urandom;
                end else begin
                    in_first = 1'b0;
                end
                in_last  = (gen_left == 1);
                in_data  = $urandom;
                in_valid = 1'b1;
            end
            out_ready = ($urandom % 10) < 7;
            cycle();
            if (last_acc) begin
                gen_left--;
                in_valid = 1'b0;
            end
        end
        while (gen_left > 0) begin
            if (!in_valid) begin
                in_first = 1'b0;
                in_last  = (gen_left == 1);
                in_data  = $urandom;
                in_valid = 1'b1;
            end
            out_ready = 1'b1;
            cycle();
            if (last_acc) begin
                gen_left--;
                in_valid = 1'b0;
            end
        end
        drain();
        check(m_data.size() == 0, "R2", "all random beats delivered", 64'(m_data.size()), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule